// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block moves data between two ports, A and B, in two directions that work independently: A-to-B and B-to-A. Each direction owns one storage element that joins a level-sensitive latch and an edge-triggered register. When the direction's latch enable is high, the storage follows the source port. When the latch enable is low, the storage keeps its value, except that a rising edge on the direction's own capture clock loads the source port.

All logic runs on one system clock. The latch enables and the direction capture clocks are sampled on that clock, and a capture edge is a sampled low-to-high change of the capture clock. Each port input arrives as a value vector with a per-bit driven flag. Each output leaves as a value vector with a per-bit drive enable, so a disabled output is high impedance.

An optional bus-hold stage makes an undriven input bit read as the last value that was actively driven on it. The output enable of A-to-B is active high and the output enable of B-to-A is active low. With that pairing, a single shared control level turns on exactly one direction.

Top module: `xcvr_bidir`

## Requirements
- R1: While a direction's latch enable is sampled high, its output value one clock later equals the source input sampled at that edge, provided the output is enabled.
- R2: While a direction's latch enable is sampled low and its capture clock shows no sampled rising edge, its stored value does not change.
- R3: With the latch enable low, a capture clock sampled high at an edge where it was sampled low at the previous edge loads the source input sampled at that edge. The result is visible one clock later.
- R4: With the latch enable high, a rising capture clock edge has no effect beyond transparent following.
- R5: `ab_oe` is active high and registered. One clock after it is sampled high, every bit of `b_drv` is 1 and `b_out` shows the A-to-B storage. One clock after it is sampled low, `b_drv` and `b_out` are all zero.
- R6: `ba_oe_n` is active low and registered. It controls `a_drv` and `a_out` from the B-to-A storage in the same way, independently of the A-to-B direction.
- R7: With `BUS_HOLD`=1 (the default), an input bit whose driven flag is 0 reads as the last value it carried while its flag was 1, or as 0 if it was never driven. With `BUS_HOLD`=0 it reads as 0.
- R8: While reset is active, and after it is released, both stores read zero and both drive enables read zero. A capture clock held high through reset release is not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_val | input | WIDTH | Value on port A |
| a_vld | input | WIDTH | Per-bit driven flag for port A |
| b_val | input | WIDTH | Value on port B |
| b_vld | input | WIDTH | Per-bit driven flag for port B |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable (high = transparent) |
| ab_clk | input | 1 | A-to-B capture clock, rising edge captures |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_clk | input | 1 | B-to-A capture clock |
| b_out | output | WIDTH | Value driven onto port B (zero when disabled) |
| b_drv | output | WIDTH | Per-bit drive enable of port B |
| a_out | output | WIDTH | Value driven onto port A (zero when disabled) |
| a_drv | output | WIDTH | Per-bit drive enable of port A |

## Verification
The hardest situation to reach is the one that tests bus-hold retention. An input is driven with a known pattern and then released while the direction is transparent. The output then has to keep that pattern, not go to zero and not take the garbage present on the value lines. Directed sequences build this case: they drive, then release with random noise on the value wires, for each direction separately. Random stimulus also releases random subsets of bits mid-stream. Another case needs an exact order of events: a capture clock that is high while the latch is open, and the latch then closes with the clock still high. It must not capture, and a dedicated directed sequence covers it.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Direction indices used across the generate structure.
  localparam int unsigned DIR_AB   = 0;
  localparam int unsigned DIR_BA   = 1;
  localparam int unsigned NUM_DIRS = 2;

  // Per-direction control as seen by the core.
  typedef struct packed {
    logic le;       // latch enable (transparent when set)
    logic cap_clk;  // sampled capture clock
    logic oe_raw;   // output enable at its pin polarity
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_bushold.sv
module xcvr_bushold #(
  parameter int unsigned WIDTH    = 18,
  parameter bit          BUS_HOLD = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] val,
  input  logic [WIDTH-1:0] vld,
  output logic [WIDTH-1:0] eff
);

  generate
    if (BUS_HOLD) begin : g_hold
      logic [WIDTH-1:0] keep_q;
      logic [WIDTH-1:0] keep_d;

      always_comb begin
        eff    = (val & vld) | (keep_q & ~vld);
        keep_d = eff;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) keep_q <= '0;
        else        keep_q <= keep_d;
      end

      // R7: a fully driven word followed by a fully released one reads back the driven word.
      p_keep_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&vld) |=> ((|vld) || (eff == $past(val))));
    end else begin : g_nohold
      always_comb eff = val & vld;
    end
  endgenerate

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             le,
  input  logic             cap_clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic             prev_clk_q;
  logic             rise;
  logic             load_en;
  logic [WIDTH-1:0] q_d;

  always_comb begin
    rise    = cap_clk & ~prev_clk_q;
    load_en = le | rise;
    q_d     = load_en ? d : q;
  end

  // The previous capture clock resets high, so a clock held high through reset is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_clk_q <= 1'b1;
      q          <= '0;
    end else begin
      prev_clk_q <= cap_clk;
      q          <= q_d;
    end
  end

  p_transparent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> (q == $past(d)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !(cap_clk && !prev_clk_q)) |=> $stable(q));

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && cap_clk && !prev_clk_q) |=> (q == $past(d)));

endmodule

// File: rtl/xcvr_outdrv.sv
module xcvr_outdrv #(
  parameter int unsigned WIDTH      = 18,
  parameter bit          ACTIVE_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oe_raw,
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] out,
  output logic [WIDTH-1:0] drv
);

  logic en_act;
  logic oe_q;

  generate
    if (ACTIVE_LOW) begin : g_low
      always_comb en_act = ~oe_raw;
    end else begin : g_high
      always_comb en_act = oe_raw;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= en_act;
  end

  always_comb begin
    drv = {WIDTH{oe_q}};
    out = oe_q ? q : '0;
  end

  // Covers R5 and R6 depending on the polarity of this instance.
  p_enable_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_act |=> (&drv));
  p_enable_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_act |=> (drv == '0 && out == '0));

endmodule

// File: rtl/xcvr_bidir.sv
module xcvr_bidir
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH    = 18,
  parameter bit          BUS_HOLD = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_val,
  input  logic [WIDTH-1:0] a_vld,
  input  logic [WIDTH-1:0] b_val,
  input  logic [WIDTH-1:0] b_vld,
  input  logic             ab_oe,
  input  logic             ab_le,
  input  logic             ab_clk,
  input  logic             ba_oe_n,
  input  logic             ba_le,
  input  logic             ba_clk,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_drv,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_drv
);

  localparam int unsigned RST_STAGES = 2;

  // Reset: asserted at once, released through a short synchronizer.
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[RST_STAGES-1];

  logic [WIDTH-1:0] src_val [NUM_DIRS];
  logic [WIDTH-1:0] src_vld [NUM_DIRS];
  dir_ctrl_t        ctrl    [NUM_DIRS];
  logic [WIDTH-1:0] dst_out [NUM_DIRS];
  logic [WIDTH-1:0] dst_drv [NUM_DIRS];

  always_comb begin
    src_val[DIR_AB] = a_val;
    src_vld[DIR_AB] = a_vld;
    src_val[DIR_BA] = b_val;
    src_vld[DIR_BA] = b_vld;
    ctrl[DIR_AB]    = '{le: ab_le, cap_clk: ab_clk, oe_raw: ab_oe};
    ctrl[DIR_BA]    = '{le: ba_le, cap_clk: ba_clk, oe_raw: ba_oe_n};
  end

  generate
    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
      logic [WIDTH-1:0] eff;
      logic [WIDTH-1:0] stored;

      xcvr_bushold #(.WIDTH(WIDTH), .BUS_HOLD(BUS_HOLD)) u_hold (
        .clk   (clk),
        .rst_n (rst_n_int),
        .val   (src_val[g]),
        .vld   (src_vld[g]),
        .eff   (eff)
      );

      xcvr_store #(.WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n_int),
        .le      (ctrl[g].le),
        .cap_clk (ctrl[g].cap_clk),
        .d       (eff),
        .q       (stored)
      );

      xcvr_outdrv #(.WIDTH(WIDTH), .ACTIVE_LOW(g == DIR_BA)) u_drv (
        .clk    (clk),
        .rst_n  (rst_n_int),
        .oe_raw (ctrl[g].oe_raw),
        .q      (stored),
        .out    (dst_out[g]),
        .drv    (dst_drv[g])
      );
    end
  endgenerate

  assign b_out = dst_out[DIR_AB];
  assign b_drv = dst_drv[DIR_AB];
  assign a_out = dst_out[DIR_BA];
  assign a_drv = dst_drv[DIR_BA];

  // R8: during reset nothing is driven.
  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n_int |-> (b_drv == '0 && a_drv == '0));

endmodule

// File: tb/tb_xcvr_bidir.sv
module tb_xcvr_bidir;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_val, a_vld, b_val, b_vld;
  logic ab_oe, ab_le, ab_clk, ba_oe_n, ba_le, ba_clk;
  logic [W-1:0] b_out, b_drv, a_out, a_drv;

  int n_checks = 0;
  int n_errors = 0;

  // Reference state per direction: 0 = A-to-B, 1 = B-to-A.
  logic [W-1:0] m_st   [2];
  logic [W-1:0] m_held [2];
  logic         m_prev [2];
  logic         m_oe   [2];

  always #10 clk = ~clk;

  xcvr_bidir #(.WIDTH(W), .BUS_HOLD(1'b1)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_val(a_val), .a_vld(a_vld), .b_val(b_val), .b_vld(b_vld),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
  );

  function automatic logic [W-1:0] f_eff(input logic [W-1:0] v, input logic [W-1:0] d,
                                         input logic [W-1:0] h);
    return (v & d) | (h & ~d);
  endfunction

  function automatic logic [W-1:0] f_next(input logic le, input logic ck, input logic pv,
                                          input logic [W-1:0] e, input logic [W-1:0] s);
    return (le || (ck && !pv)) ? e : s;
  endfunction

  task automatic model_update();
    logic [W-1:0] e0, e1;
    e0 = f_eff(a_val, a_vld, m_held[0]);
    e1 = f_eff(b_val, b_vld, m_held[1]);
    m_st[0] = f_next(ab_le, ab_clk, m_prev[0], e0, m_st[0]);
    m_st[1] = f_next(ba_le, ba_clk, m_prev[1], e1, m_st[1]);
    m_held[0] = e0; m_held[1] = e1;
    m_prev[0] = ab_clk; m_prev[1] = ba_clk;
    m_oe[0] = ab_oe; m_oe[1] = !ba_oe_n;
  endtask

  task automatic chk(input string tag, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "b_out", b_out, m_oe[0] ? m_st[0] : '0);
    chk(tag, "b_drv", b_drv, {W{m_oe[0]}});
    chk(tag, "a_out", a_out, m_oe[1] ? m_st[1] : '0);
    chk(tag, "a_drv", a_drv, {W{m_oe[1]}});
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic quiet();
    a_val = '0; a_vld = '0; b_val = '0; b_vld = '0;
    ab_oe = 1'b0; ab_le = 1'b0; ab_clk = 1'b1;
    ba_oe_n = 1'b1; ba_le = 1'b0; ba_clk = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin : main
    logic [W-1:0] pat;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    quiet();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: outputs idle during reset.
    chk("R8", "b_drv in reset", b_drv, '0);
    chk("R8", "a_drv in reset", a_drv, '0);
    rst_n = 1'b1;
    // Capture clocks stay high across release: R8 says this is no edge.
    ab_oe = 1'b1; ba_oe_n = 1'b0;
    a_val = 18'h3FFFF; a_vld = '1; b_val = 18'h3FFFF; b_vld = '1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R8", "b_out after release, clock held high", b_out, '0);
    chk("R8", "a_out after release, clock held high", a_out, '0);
    chk("R8", "b_drv after release", b_drv, '1);
    m_st[0] = '0; m_st[1] = '0;
    m_held[0] = a_val; m_held[1] = b_val;
    m_prev[0] = 1'b1; m_prev[1] = 1'b1;
    m_oe[0] = 1'b1; m_oe[1] = 1'b1;

    // R1 transparent following, several patterns.
    ab_le = 1'b1; ba_le = 1'b1; ab_clk = 1'b0; ba_clk = 1'b0;
    a_val = 18'h2AAAA; b_val = 18'h15555; step("R1");
    a_val = 18'h00001; b_val = 18'h20000; step("R1");
    // R4: rising capture clock while transparent changes nothing extra.
    ab_clk = 1'b1; ba_clk = 1'b1; a_val = 18'h12345; b_val = 18'h0BEEF; step("R4");
    // Close the latch with the clock still high: no edge, so hold (R2).
    ab_le = 1'b0; ba_le = 1'b0; a_val = 18'h3C3C3; b_val = 18'h0F0F0; step("R2");
    step("R2");
    // R2: steady low clock holds.
    ab_clk = 1'b0; ba_clk = 1'b0; a_val = 18'h11111; step("R2");
    // R3: edge capture.
    ab_clk = 1'b1; a_val = 18'h2468A; step("R3");
    ba_clk = 1'b1; b_val = 18'h13579; a_val = 18'h3FFFF; step("R3");
    // R5: A-to-B disable while B-to-A stays on.
    ab_oe = 1'b0; step("R5");
    chk("R5", "b_out high impedance", b_out, '0);
    ab_oe = 1'b1; step("R5");
    // R6: active-low disable of B-to-A.
    ba_oe_n = 1'b1; step("R6");
    chk("R6", "a_drv released", a_drv, '0);
    ba_oe_n = 1'b0; step("R6");

    // R7: drive, then release with noise on value lines, each direction.
    ab_le = 1'b1; ba_le = 1'b1;
    pat = 18'h2D2D2; a_val = pat; a_vld = '1; b_val = ~pat; b_vld = '1; step("R7");
    a_vld = '0; a_val = 18'h3FFFF; step("R7");
    a_val = 18'h00000; step("R7");
    chk("R7", "b_out keeps driven word", b_out, pat);
    b_vld = 18'h000FF; b_val = 18'h0; step("R7");
    chk("R7", "a_out partial hold", a_out, (~pat) & 18'h3FF00);

    // Random phase.
    for (int i = 0; i < 3000; i++) begin
      string tg;
      a_val = W'($urandom); b_val = W'($urandom);
      a_vld = ($urandom % 8 == 0) ? W'($urandom) : '1;
      b_vld = ($urandom % 8 == 0) ? W'($urandom) : '1;
      ab_le = ($urandom % 4 == 0); ba_le = ($urandom % 4 == 0);
      ab_clk = $urandom % 2; ba_clk = $urandom % 2;
      ab_oe = ($urandom % 5 != 0); ba_oe_n = ($urandom % 5 == 0);
      if (ab_le) tg = "R1";
      else if (ab_clk && !m_prev[0]) tg = "R3";
      else tg = "R2";
      step(tg);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule